// File: doc/BRIEF.md
# Supervisor Reset Timer with Fault Capture

This block turns several fault sources into one system reset. The sources are a power-up event, three low-voltage comparator flags, a manual reset request and a watchdog timeout. Once every source has gone quiet, the reset is held for a further delay, and two configuration pins select that delay. A watchdog timer runs next to the reset logic. Two more configuration pins set its period, and one of their codes turns the watchdog off. Software keeps the watchdog from firing by pulsing a kick input.

Each reset cause is latched into a sticky byte-wide cause register. Software reads this register after reset to find out why the system went down. The host clears or rewrites the register with a single-byte write. The write must carry a fixed device-select code and a fixed register address, and it needs no unlock step. All timing is counted in ticks of an internal prescaler, so simulations can use short delays while silicon uses the real millisecond values.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good` is low, `rst_hi` is 1, `rst_lo` is 0 and `cause` is 0x00. After `pwr_good` rises, reset is held for the delay selected by `pup_sel` and then released.
- R2: The stretch delay comes from `pup_sel`: 00 gives DLY_0, 01 gives DLY_1, 10 gives DLY_2 and 11 gives DLY_3 ticks. The defaults are 5, 20, 40 and 80 ticks of TICK_DIV (4) clocks. After the last source drops, reset ends between (D-1)*TICK_DIV and D*TICK_DIV+1 clocks later.
- R3: When any bit of `lv_fault` or `man_rst` is high, reset is asserted from the next clock. Reset stays asserted while the source is high, and the stretch delay starts again only once the source drops.
- R4: The watchdog period comes from `wd_sel`: 00 gives WDP_0 (60) ticks, 01 gives WDP_1 (10) ticks, 10 gives WDP_2 (3) ticks, and 11 turns the watchdog off.
- R5: A high `wd_kick`, an asserted reset, or a change of `wd_sel` reloads the watchdog counter. When the counter expires, reset is asserted and the watchdog flag is set.
- R6: While `wd_sel` is 11, the watchdog never expires, however long no kick arrives.
- R7: The cause register bits are: bit 7 for `lv_fault[0]`, bit 6 for `lv_fault[1]`, bit 5 for `lv_fault[2]`, bit 4 for watchdog expiry and bit 3 for `man_rst`. Bits 2:0 always read as 0.
- R8: The flags are sticky. A write replaces bits 7:3 with `host_wdata[7:3]` only when `host_wr` is high, `host_pre` is 4'b1011 and `host_addr` is 8'hFF. Any other write leaves the register unchanged.
- R9: If a host write and a flag's source fall in the same cycle, the flag ends up set.
- R10: When `pwr_good` drops, every flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply good; when low it is an asynchronous power-on reset |
| lv_fault | input | 3 | Low-voltage comparator flags, high means under threshold |
| man_rst | input | 1 | Manual reset request, active high |
| wd_kick | input | 1 | Watchdog service strobe |
| pup_sel | input | 2 | Reset stretch delay select |
| wd_sel | input | 2 | Watchdog period select, 11 turns it off |
| host_wr | input | 1 | Host byte write strobe |
| host_pre | input | 4 | Device-select code of the write |
| host_addr | input | 8 | Register address of the write |
| host_wdata | input | 8 | Write data |
| rst_hi | output | 1 | System reset, active high |
| rst_lo | output | 1 | System reset, active low |
| cause | output | 8 | Reset cause register |

## Verification
The collision that matters is a host write to the cause register landing in the same cycle as a new fault. The bench drives a clearing write (data 0x00) together with a one-cycle pulse on a low-voltage flag. It expects that flag's bit to read back as set while every other bit is cleared. A second overlap comes from a watchdog whose period has run out while reset is still held. The bench keeps reset asserted far longer than the watchdog period and checks that no watchdog flag appears.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef enum logic [1:0] {
      WD_LONG  = 2'b00,
      WD_MID   = 2'b01,
      WD_SHORT = 2'b10,
      WD_OFF   = 2'b11
   } wd_code_e;

   localparam int CAUSE_W   = 8;
   localparam int N_FLAGS   = 5;
   localparam logic [3:0] CAUSE_PRE  = 4'b1011;
   localparam logic [7:0] CAUSE_ADDR = 8'hFF;

   // flag order inside the set vector, highest index lands on bit 7
   localparam int FI_LV1 = 4;
   localparam int FI_LV2 = 3;
   localparam int FI_LV3 = 2;
   localparam int FI_WDF = 1;
   localparam int FI_MRF = 0;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rsup_tick.sv
module rsup_tick #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("rsup_tick: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            pcnt <= '0;
         else if (pcnt == LAST) pcnt <= '0;
         else                   pcnt <= pcnt + 1'b1;
      end

      assign tick = (pcnt == LAST);
   end
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
   parameter int DLY_0 = 5,
   parameter int DLY_1 = 20,
   parameter int DLY_2 = 40,
   parameter int DLY_3 = 80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       src,
   input  logic [1:0] pup_sel,
   output logic       active
);
   localparam int DMAX = rsup_pkg::imax(rsup_pkg::imax(DLY_0, DLY_1),
                                        rsup_pkg::imax(DLY_2, DLY_3));
   localparam int DW = $clog2(DMAX + 1);

   if (DLY_0 < 1 || DLY_1 < 1 || DLY_2 < 1 || DLY_3 < 1) begin : g_bad_dly
      $error("rsup_stretch: every delay needs at least one tick");
   end

   logic [DW-1:0] cnt;
   logic [DW-1:0] load_val;
   logic          por_pend;

   always_comb begin
      unique case (pup_sel)
         2'b00:   load_val = DW'(DLY_0);
         2'b01:   load_val = DW'(DLY_1);
         2'b10:   load_val = DW'(DLY_2);
         default: load_val = DW'(DLY_3);
      endcase
   end

   // R1: counter leaves reset non-zero, first live cycle loads the chosen delay
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= DW'(1);
         por_pend <= 1'b1;
      end else begin
         por_pend <= 1'b0;
         if (src || por_pend)
            cnt <= load_val;
         else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end

   assign active = (cnt != '0);

   assert_src_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      src |=> active);

   assert_release_after_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> !$past(src));
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
   import rsup_pkg::*;
#(
   parameter int WDP_0 = 60,
   parameter int WDP_1 = 10,
   parameter int WDP_2 = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       kick,
   input  logic       hold,
   input  logic [1:0] wd_sel,
   output logic       expire
);
   localparam int PMAX = imax(imax(WDP_0, WDP_1), WDP_2);
   localparam int PW   = $clog2(PMAX + 1);

   if (WDP_0 < 1 || WDP_1 < 1 || WDP_2 < 1) begin : g_bad_per
      $error("rsup_watchdog: every period needs at least one tick");
   end

   wd_code_e      code, code_q;
   logic [PW-1:0] cnt;
   logic [PW-1:0] period;
   logic          reload;

   assign code = wd_code_e'(wd_sel);

   always_comb begin
      unique case (code)
         WD_LONG:  period = PW'(WDP_0);
         WD_MID:   period = PW'(WDP_1);
         WD_SHORT: period = PW'(WDP_2);
         default:  period = PW'(WDP_0);
      endcase
   end

   // R5: kick, held reset or a new period code restart the count; R6: off code parks it
   assign reload = kick || hold || (code != code_q) || (code == WD_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= PW'(WDP_0);
         code_q <= WD_OFF;
         expire <= 1'b0;
      end else begin
         code_q <= code;
         if (reload) begin
            cnt    <= period;
            expire <= 1'b0;
         end else if (tick) begin
            if (cnt <= PW'(1)) begin
               cnt    <= period;
               expire <= 1'b1;
            end else begin
               cnt    <= cnt - 1'b1;
               expire <= 1'b0;
            end
         end else begin
            expire <= 1'b0;
         end
      end
   end

   assert_kick_blocks_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !expire);

   assert_off_never_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_sel == 2'b11) |=> !expire);
endmodule

// File: rtl/rsup_cause.sv
module rsup_cause #(
   parameter int REG_W = 8,
   parameter int NFLAG = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic             wr_hit,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] status
);
   localparam int ZB = REG_W - NFLAG;

   if (NFLAG < 1 || NFLAG >= REG_W) begin : g_bad_width
      $error("rsup_cause: flags must fit below the register width with one zero bit");
   end

   logic [NFLAG-1:0] flags;

   // R8/R9: a write replaces the flags, then any live source is ORed on top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags <= '0;
      else if (wr_hit) flags <= wdata[REG_W-1:ZB] | set;
      else             flags <= flags | set;
   end

   assign status = {flags, {ZB{1'b0}}};

   for (genvar i = 0; i < NFLAG; i++) begin : g_chk
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> status[ZB+i]);

      assert_flag_rise_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status[ZB+i]) |-> $past(set[i] || wr_hit));
   end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
   import rsup_pkg::*;
#(
   parameter int TICK_DIV = 4,
   parameter int DLY_0    = 5,
   parameter int DLY_1    = 20,
   parameter int DLY_2    = 40,
   parameter int DLY_3    = 80,
   parameter int WDP_0    = 60,
   parameter int WDP_1    = 10,
   parameter int WDP_2    = 3
) (
   input  logic       clk,
   input  logic       pwr_good,
   input  logic [2:0] lv_fault,
   input  logic       man_rst,
   input  logic       wd_kick,
   input  logic [1:0] pup_sel,
   input  logic [1:0] wd_sel,
   input  logic       host_wr,
   input  logic [3:0] host_pre,
   input  logic [7:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic       rst_hi,
   output logic       rst_lo,
   output logic [7:0] cause
);
   logic                rst_n;
   logic                tick;
   logic                wd_exp;
   logic                src;
   logic                active;
   logic                wr_hit;
   logic [N_FLAGS-1:0]  set_vec;

   assign rst_n = pwr_good;   // R1, R10: supply loss clears every register

   rsup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   assign src = (|lv_fault) | man_rst | wd_exp;

   rsup_stretch #(
      .DLY_0(DLY_0), .DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)
   ) u_stretch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .src     (src),
      .pup_sel (pup_sel),
      .active  (active)
   );

   rsup_watchdog #(
      .WDP_0(WDP_0), .WDP_1(WDP_1), .WDP_2(WDP_2)
   ) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .kick   (wd_kick),
      .hold   (active),
      .wd_sel (wd_sel),
      .expire (wd_exp)
   );

   // R7: flag placement in the cause byte
   always_comb begin
      set_vec         = '0;
      set_vec[FI_LV1] = lv_fault[0];
      set_vec[FI_LV2] = lv_fault[1];
      set_vec[FI_LV3] = lv_fault[2];
      set_vec[FI_WDF] = wd_exp;
      set_vec[FI_MRF] = man_rst;
   end

   assign wr_hit = host_wr && (host_pre == CAUSE_PRE) && (host_addr == CAUSE_ADDR);

   rsup_cause #(.REG_W(CAUSE_W), .NFLAG(N_FLAGS)) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (set_vec),
      .wr_hit (wr_hit),
      .wdata  (host_wdata),
      .status (cause)
   );

   assign rst_hi = active;
   assign rst_lo = ~active;

   assert_wdog_raises_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_exp |=> (rst_hi && cause[4]));
endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       pwr_good = 1'b0;
   logic [2:0] lv_fault = '0;
   logic       man_rst = 1'b0;
   logic       wd_kick = 1'b0;
   logic [1:0] pup_sel = 2'b01;
   logic [1:0] wd_sel = 2'b11;
   logic       host_wr = 1'b0;
   logic [3:0] host_pre = '0;
   logic [7:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       rst_hi, rst_lo;
   logic [7:0] cause;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_supervisor dut (
      .clk(clk), .pwr_good(pwr_good), .lv_fault(lv_fault), .man_rst(man_rst),
      .wd_kick(wd_kick), .pup_sel(pup_sel), .wd_sel(wd_sel), .host_wr(host_wr),
      .host_pre(host_pre), .host_addr(host_addr), .host_wdata(host_wdata),
      .rst_hi(rst_hi), .rst_lo(rst_lo), .cause(cause)
   );

   typedef struct {
      string req;
      int    kind;   // 0 rst_hi, 1 rst_lo, 2 cause, 3 measured value in act
      int    act;
      int    lo;
      int    hi;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic push(input string req, input int kind, input int exp_v);
      item_t it;
      it.req = req; it.kind = kind; it.act = 0; it.lo = exp_v; it.hi = exp_v;
      q.push_back(it);
   endtask

   task automatic push_range(input string req, input int act, input int lo, input int hi);
      item_t it;
      it.req = req; it.kind = 3; it.act = act; it.lo = lo; it.hi = hi;
      q.push_back(it);
   endtask

   // monitor: scores queued expectations just after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            int    a;
            it = q.pop_front();
            case (it.kind)
               0: a = int'(rst_hi);
               1: a = int'(rst_lo);
               2: a = int'(cause);
               default: a = it.act;
            endcase
            checks++;
            if (a < it.lo || a > it.hi) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%0d expected=[%0d,%0d]",
                        it.req, it.kind, a, it.lo, it.hi);
            end
         end
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_low(output int n);
      n = 0;
      while (rst_hi && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_high(output int n);
      n = 0;
      while (!rst_hi && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic host_write(input logic [3:0] pre, input logic [7:0] addr, input logic [7:0] d);
      host_wr = 1'b1; host_pre = pre; host_addr = addr; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_pre = '0; host_addr = '0; host_wdata = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog timeout: bench hung");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      @(negedge clk);
      cycles(2);
      // R1: supply low state
      push("R1 rst_hi in power-down", 0, 1);
      push("R1 rst_lo in power-down", 1, 0);
      push("R1 cause cleared in power-down", 2, 0);
      cycles(1);

      // R1/R2: power-up stretch with code 01
      pwr_good = 1'b1;
      wait_low(n);
      push_range("R1 R2 power-up stretch code01", n, 19*DIV, 20*DIV+2);
      push("R7 no flag after clean power-up", 2, 8'h00);
      cycles(1);

      // R3/R7: low-voltage flag 1, code 00
      pup_sel = 2'b00;
      lv_fault[0] = 1'b1;
      cycles(1);
      push("R3 reset one cycle after lv_fault", 0, 1);
      push("R7 lv_fault[0] lands on bit 7", 2, 8'h80);
      cycles(30);
      push("R3 reset held while source high", 0, 1);
      lv_fault[0] = 1'b0;
      wait_low(n);
      push_range("R2 R3 stretch code00 after release", n, 4*DIV, 5*DIV+1);
      cycles(1);

      // R8: misdirected writes ignored, valid writes replace, low bits stay zero
      host_write(4'b1010, 8'hFF, 8'h00);
      push("R8 wrong device code ignored", 2, 8'h80);
      host_write(4'b1011, 8'hFE, 8'h00);
      push("R8 wrong address ignored", 2, 8'h80);
      host_write(4'b1011, 8'hFF, 8'h00);
      push("R8 valid write clears", 2, 8'h00);
      host_write(4'b1011, 8'hFF, 8'hFF);
      push("R7 R8 bits 2:0 read zero after 0xFF write", 2, 8'hF8);
      host_write(4'b1011, 8'hFF, 8'h00);
      push("R8 cleared again", 2, 8'h00);
      cycles(1);

      // R2/R7: manual reset with code 11
      pup_sel = 2'b11;
      man_rst = 1'b1;
      cycles(1);
      push("R7 manual reset on bit 3", 2, 8'h08);
      push("R3 manual reset asserts reset", 1, 0);
      cycles(3);
      man_rst = 1'b0;
      wait_low(n);
      push_range("R2 stretch code11", n, 79*DIV, 80*DIV+1);
      cycles(1);

      // R2/R7: lv_fault[2] with code 10
      pup_sel = 2'b10;
      lv_fault[2] = 1'b1;
      cycles(1);
      push("R7 lv_fault[2] on bit 5, bit 3 sticky", 2, 8'h28);
      lv_fault[2] = 1'b0;
      wait_low(n);
      push_range("R2 stretch code10", n, 39*DIV, 40*DIV+1);
      cycles(1);

      // R9: clearing write in the same cycle as a new fault
      pup_sel = 2'b00;
      host_wr = 1'b1; host_pre = 4'b1011; host_addr = 8'hFF; host_wdata = 8'h00;
      lv_fault[1] = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_pre = '0; host_addr = '0;
      lv_fault[1] = 1'b0;
      push("R9 fault wins over same-cycle clear", 2, 8'h40);
      wait_low(n);
      host_write(4'b1011, 8'hFF, 8'h00);
      cycles(1);

      // R6: watchdog off never fires
      wd_sel = 2'b11;
      cycles(300);
      push("R6 no reset with watchdog off", 0, 0);
      push("R6 no flag with watchdog off", 2, 8'h00);

      // R4/R5: periodic kicks hold off the short period
      wd_sel = 2'b10;
      for (int k = 0; k < 20; k++) begin
         wd_kick = 1'b1;
         @(negedge clk);
         wd_kick = 1'b0;
         cycles(2);
      end
      push("R5 kicked watchdog stays quiet", 0, 0);
      push("R5 no watchdog flag while kicked", 2, 8'h00);

      // R4/R5: expiry after last kick, code 10 = 3 ticks
      wd_kick = 1'b1;
      @(negedge clk);
      wd_kick = 1'b0;
      wait_high(n);
      wd_sel = 2'b11;
      push_range("R4 R5 expiry timing code10", n + 1, 2*DIV+2, 3*DIV+3);
      push("R5 expiry sets watchdog flag", 2, 8'h10);
      wait_low(n);
      host_write(4'b1011, 8'hFF, 8'h00);

      // R5: held reset reloads the watchdog
      wd_sel = 2'b10;
      lv_fault[0] = 1'b1;
      cycles(100);
      lv_fault[0] = 1'b0;
      wait_low(n);
      push("R5 no expiry while reset held", 2, 8'h80);
      wd_sel = 2'b11;
      cycles(1);

      // R4: medium period, code 01 = 10 ticks
      wd_sel = 2'b01;
      cycles(1);
      wd_kick = 1'b1;
      @(negedge clk);
      wd_kick = 1'b0;
      wait_high(n);
      wd_sel = 2'b11;
      push_range("R4 expiry timing code01", n + 1, 9*DIV+2, 10*DIV+3);
      push("R4 watchdog flag with code01", 2, 8'h90);
      wait_low(n);

      // R10: supply loss clears flags
      pwr_good = 1'b0;
      cycles(2);
      push("R10 flags cleared by power loss", 2, 8'h00);
      push("R1 reset asserted at power loss", 0, 1);
      pwr_good = 1'b1;
      cycles(3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule